// File: doc/BRIEF.md
# Single-Pin GPIO Operation Unit

This block carries out one-pin I/O operations for a processor core over a flat pin space. The core passes an opcode, a source operand whose low nine bits name the pin, its current carry flag and a start strobe. The block can drive the named pin high or low, drive it from carry, return the pin's input level through carry, set the pin's direction, or hold the core in a stall until the pin's input reaches a requested level.

The pin space is 512 entries wide, but only `PIN_COUNT` pins are built. An index that names an unbuilt pin is harmless. Pins 0 to 31 can also be written as a 32-bit group, so older whole-port output and direction writes keep working next to the single-pin operations. The synchronized levels of those 32 pins are returned as a group as well. Every pin input passes through a two-stage synchronizer before any operation uses it.

Top module: `gpioPinUnit`

## Requirements
- R1: After reset all pin outputs, all pin directions, the carry output and busy are 0.
- R2: Opcode 0 sets the named pin's output to 1 and opcode 1 clears it to 0. The new value is visible the cycle after the start strobe.
- R3: Opcode 3 drives the named pin's output to the value of carryIn. It leaves carryOut unchanged.
- R4: Opcode 2 loads the named pin's synchronized input level into carryOut. No other opcode changes carryOut.
- R5: Opcode 4 sets the pin's direction to input (0) and opcode 5 sets it to output (1). Opcode 6 copies carryIn into the direction.
- R6: Only bits 8:0 of the operand select the pin. Bits 31:9 are ignored.
- R7: An index at or above `PIN_COUNT` changes no output and no direction. A read on such an index returns 0 in carry. A wait on such an index never raises busy.
- R8: Opcode 7 waits for level 0 and opcode 8 waits for level 1. Busy rises the cycle after the start strobe. It falls one cycle after the synchronized level of the pin matches the requested level.
- R9: A change on a pin input reaches a read only after two clock edges of synchronization.
- R10: While grpOutWe is high, pinOut[31:0] takes grpOutData. While grpDirWe is high, pinDir[31:0] takes grpDirData. Pins 32 and up are not touched. grpIn returns the synchronized levels of pins 0 to 31.
- R11: If a single-pin write and a group write hit the same pin in the same cycle, the single-pin write wins on that pin. The other pins take the group value.
- R12: A start strobe while busy is ignored. Opcodes 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe for one operation |
| opcode | input | 4 | Operation code |
| operand | input | 32 | Source operand; bits 8:0 name the pin |
| carryIn | input | 1 | Core carry flag |
| carryOut | output | 1 | Carry result register |
| busy | output | 1 | Stall request while a wait is pending |
| pinIn | input | PIN_COUNT | Raw pin input levels |
| pinOut | output | PIN_COUNT | Pin output values |
| pinDir | output | PIN_COUNT | Pin directions, 1 = output |
| grpOutWe | input | 1 | Group write strobe for outputs of pins 0-31 |
| grpOutData | input | 32 | Group output data |
| grpDirWe | input | 1 | Group write strobe for directions of pins 0-31 |
| grpDirData | input | 32 | Group direction data |
| grpIn | output | 32 | Synchronized inputs of pins 0-31 |

## Verification
The bench puts garbage in the upper operand bits. A design that decodes the full operand would then hit the wrong pin or treat the index as out of range. It also targets indices just past the built pins. A design that does not check the range would alias onto a real pin, or would hang on a wait that can never finish. The bench changes an input and reads the pin at once, then again two cycles later, and times the fall of busy to the exact cycle. This catches a synchronizer with a missing or extra stage and a wait that releases one cycle off. Finally, a single-pin clear is issued in the same cycle as a group write. A design with the wrong priority would lose the clear or corrupt the neighbouring bits.

// File: rtl/gpioPinPkg.sv
package gpioPinPkg;
  // width of the architectural pin index
  localparam int PIN_SPACE_BITS = 9;
  localparam int GROUP_W = 32;

  typedef enum logic [3:0] {
    OP_SET       = 4'd0,
    OP_CLR       = 4'd1,
    OP_READ      = 4'd2,
    OP_WRITE     = 4'd3,
    OP_DIR_IN    = 4'd4,
    OP_DIR_OUT   = 4'd5,
    OP_DIR_CARRY = 4'd6,
    OP_WAIT_LO   = 4'd7,
    OP_WAIT_HI   = 4'd8
  } pinOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic [PIN_SPACE_BITS-1:0] idx;
    logic                      inRange;
    logic                      wrOut;
    logic                      outVal;
    logic                      wrDir;
    logic                      dirVal;
    logic                      loadCarry;
  } pinStrobeT;
endpackage

// File: rtl/gpioSync.sv
module gpioSync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      stageA <= rawIn;
      stageB <= stageA;
    end
  end

  assign syncOut = stageB;
endmodule

// File: rtl/gpioPinCtrl.sv
module gpioPinCtrl
  import gpioPinPkg::*;
#(
  parameter int PIN_COUNT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  opcode,
  input  logic [31:0] operand,
  input  logic        carryIn,
  input  logic        selLevel,
  output pinStrobeT   strobe,
  output logic        busy
);
  localparam logic [PIN_SPACE_BITS:0] LIMIT = (PIN_SPACE_BITS+1)'(PIN_COUNT);

  typedef enum logic {ST_IDLE, ST_WAIT} stateE;

  stateE                     state;
  logic [PIN_SPACE_BITS-1:0] heldIdx;
  logic                      heldLevel;
  logic [PIN_SPACE_BITS-1:0] curIdx;
  logic                      inRange;
  logic                      accept;
  logic                      isWait;

  assign curIdx  = (state == ST_WAIT) ? heldIdx : operand[PIN_SPACE_BITS-1:0];
  assign inRange = {1'b0, curIdx} < LIMIT;
  assign accept  = start && (state == ST_IDLE);
  assign isWait  = (opcode == OP_WAIT_LO) || (opcode == OP_WAIT_HI);

  always_comb begin
    strobe         = '0;
    strobe.idx     = curIdx;
    strobe.inRange = inRange;
    if (accept && inRange) begin
      unique case (opcode)
        OP_SET:       begin strobe.wrOut = 1'b1; strobe.outVal = 1'b1; end
        OP_CLR:       begin strobe.wrOut = 1'b1; strobe.outVal = 1'b0; end
        OP_WRITE:     begin strobe.wrOut = 1'b1; strobe.outVal = carryIn; end
        OP_DIR_IN:    begin strobe.wrDir = 1'b1; strobe.dirVal = 1'b0; end
        OP_DIR_OUT:   begin strobe.wrDir = 1'b1; strobe.dirVal = 1'b1; end
        OP_DIR_CARRY: begin strobe.wrDir = 1'b1; strobe.dirVal = carryIn; end
        default: ;
      endcase
    end
    // read of an unbuilt pin still loads carry (with 0)
    if (accept && opcode == OP_READ) strobe.loadCarry = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldIdx   <= '0;
      heldLevel <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept && isWait && inRange) begin
          state     <= ST_WAIT;
          heldIdx   <= operand[PIN_SPACE_BITS-1:0];
          heldLevel <= (opcode == OP_WAIT_HI);
        end
        ST_WAIT: if (selLevel == heldLevel) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT);
endmodule

// File: rtl/gpioPinDatapath.sv
module gpioPinDatapath
  import gpioPinPkg::*;
#(
  parameter int PIN_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pinStrobeT            strobe,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 grpOutWe,
  input  logic [GROUP_W-1:0]   grpOutData,
  input  logic                 grpDirWe,
  input  logic [GROUP_W-1:0]   grpDirData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinDir,
  output logic                 carryOut,
  output logic                 selLevel,
  output logic [GROUP_W-1:0]   grpIn
);
  logic [PIN_COUNT-1:0] syncIn;

  gpioSync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (pinIn),
    .syncOut(syncIn)
  );

  always_comb begin
    selLevel = 1'b0;
    for (int i = 0; i < PIN_COUNT; i++) begin
      if (strobe.idx == PIN_SPACE_BITS'(i)) selLevel = syncIn[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < PIN_COUNT; g++) begin : gPin
      logic hitPin;
      assign hitPin = strobe.inRange && (strobe.idx == PIN_SPACE_BITS'(g));
      if (g < GROUP_W) begin : gGrouped
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pinOut[g] <= 1'b0;
            pinDir[g] <= 1'b0;
          end else begin
            if (strobe.wrOut && hitPin) pinOut[g] <= strobe.outVal;
            else if (grpOutWe)          pinOut[g] <= grpOutData[g];
            if (strobe.wrDir && hitPin) pinDir[g] <= strobe.dirVal;
            else if (grpDirWe)          pinDir[g] <= grpDirData[g];
          end
        end
      end else begin : gPlain
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pinOut[g] <= 1'b0;
            pinDir[g] <= 1'b0;
          end else begin
            if (strobe.wrOut && hitPin) pinOut[g] <= strobe.outVal;
            if (strobe.wrDir && hitPin) pinDir[g] <= strobe.dirVal;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 carryOut <= 1'b0;
    else if (strobe.loadCarry) carryOut <= selLevel & strobe.inRange;
  end

  assign grpIn = syncIn[GROUP_W-1:0];
endmodule

// File: rtl/gpioPinUnit.sv
module gpioPinUnit
  import gpioPinPkg::*;
#(
  parameter int PIN_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           opcode,
  input  logic [31:0]          operand,
  input  logic                 carryIn,
  output logic                 carryOut,
  output logic                 busy,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinDir,
  input  logic                 grpOutWe,
  input  logic [31:0]          grpOutData,
  input  logic                 grpDirWe,
  input  logic [31:0]          grpDirData,
  output logic [31:0]          grpIn
);
  pinStrobeT strobe;
  logic      selLevel;

  gpioPinCtrl #(.PIN_COUNT(PIN_COUNT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .operand (operand),
    .carryIn (carryIn),
    .selLevel(selLevel),
    .strobe  (strobe),
    .busy    (busy)
  );

  gpioPinDatapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pinIn     (pinIn),
    .grpOutWe  (grpOutWe),
    .grpOutData(grpOutData),
    .grpDirWe  (grpDirWe),
    .grpDirData(grpDirData),
    .pinOut    (pinOut),
    .pinDir    (pinDir),
    .carryOut  (carryOut),
    .selLevel  (selLevel),
    .grpIn     (grpIn)
  );
endmodule

// File: rtl/gpioPinUnitChk.sv
module gpioPinUnitChk #(
  parameter int PIN_COUNT = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic [3:0]           opcode,
  input logic [31:0]          operand,
  input logic                 carryOut,
  input logic                 busy,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinDir,
  input logic                 grpOutWe,
  input logic                 grpDirWe
);
  localparam logic [PIN_COUNT-1:0] ONE_HOT = PIN_COUNT'(1);

  logic       live;
  logic       inRange;
  logic [8:0] prevIdx;

  assign live    = start && !busy;
  assign inRange = {1'b0, operand[8:0]} < 10'(PIN_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIdx <= '0;
    else       prevIdx <= operand[8:0];
  end

  a_r2_set_visible: assert property (@(posedge clk) disable iff (!rstN)
    live && opcode == 4'd0 && inRange |=> |(pinOut & (ONE_HOT << prevIdx)));

  a_r4_carry_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(live && opcode == 4'd2) |=> $stable(carryOut));

  a_r7_unbuilt_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    live && !inRange && !grpOutWe && !grpDirWe |=> $stable(pinOut) && $stable(pinDir) && !busy);

  a_r8_wait_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    live && (opcode == 4'd7 || opcode == 4'd8) && inRange |=> busy);

  a_r12_start_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && !grpOutWe && !grpDirWe |=> $stable(pinOut) && $stable(pinDir) && $stable(carryOut));
endmodule

bind gpioPinUnit gpioPinUnitChk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opcode  (opcode),
  .operand (operand),
  .carryOut(carryOut),
  .busy    (busy),
  .pinOut  (pinOut),
  .pinDir  (pinDir),
  .grpOutWe(grpOutWe),
  .grpDirWe(grpDirWe)
);

// File: tb/gpioPinUnit_tb.sv
module gpioPinUnit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 64;
  localparam int NVEC = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [3:0]      opcode = '0;
  logic [31:0]     operand = '0;
  logic            carryIn = 1'b0;
  logic            carryOut;
  logic            busy;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut;
  logic [PINS-1:0] pinDir;
  logic            grpOutWe = 1'b0;
  logic [31:0]     grpOutData = '0;
  logic            grpDirWe = 1'b0;
  logic [31:0]     grpDirData = '0;
  logic [31:0]     grpIn;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpioPinUnit #(.PIN_COUNT(PINS)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .carryIn(carryIn), .carryOut(carryOut), .busy(busy), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .grpOutWe(grpOutWe), .grpOutData(grpOutData),
    .grpDirWe(grpDirWe), .grpDirData(grpDirData), .grpIn(grpIn)
  );

  // row: [47:40] req, [39:36] op, [35:4] operand, [3] carryIn,
  //      [2] expected out bit, [1] expected dir bit, [0] expected carry
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd2, 4'd0, 32'd10,          1'b0, 3'b100}, // R2 set pin 10
    {8'd5, 4'd5, 32'd10,          1'b0, 3'b110}, // R5 dir out
    {8'd6, 4'd1, 32'hFFFF_FE0A,   1'b0, 3'b010}, // R6 clear via masked index
    {8'd4, 4'd2, 32'd5,           1'b0, 3'b001}, // R4 read high pin
    {8'd4, 4'd2, 32'd6,           1'b0, 3'b000}, // R4 read low pin
    {8'd3, 4'd3, 32'd40,          1'b1, 3'b100}, // R3 write from carry
    {8'd5, 4'd6, 32'd40,          1'b1, 3'b110}, // R5 dir from carry 1
    {8'd5, 4'd6, 32'd40,          1'b0, 3'b100}, // R5 dir from carry 0
    {8'd6, 4'd2, 32'd552,         1'b0, 3'b101}, // R6 read, upper bits ignored
    {8'd5, 4'd4, 32'd10,          1'b0, 3'b001}  // R5 dir in
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] opnd, input logic cin);
    start = 1'b1; opcode = op; operand = opnd; carryIn = cin;
    @(negedge clk);
    start = 1'b0; opcode = 4'd15; operand = '0; carryIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [PINS-1:0] saveOut;
    logic [PINS-1:0] saveDir;
    pinIn = (64'd1 << 5) | (64'd1 << 40);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pinOut", pinOut, '0);
    check("R1", "pinDir", pinDir, '0);
    check("R1", "carryOut", {63'd0, carryOut}, 64'd0);
    check("R1", "busy", {63'd0, busy}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      string rq;
      int p;
      rq = $sformatf("R%0d", VEC[k][47:40]);
      p = int'(VEC[k][12:4]);
      issue(VEC[k][39:36], VEC[k][35:4], VEC[k][3]);
      check(rq, $sformatf("row %0d out", k), {63'd0, pinOut[p]}, {63'd0, VEC[k][2]});
      check(rq, $sformatf("row %0d dir", k), {63'd0, pinDir[p]}, {63'd0, VEC[k][1]});
      check(rq, $sformatf("row %0d carry", k), {63'd0, carryOut}, {63'd0, VEC[k][0]});
    end

    // R9: fresh input is not seen until two edges later
    issue(4'd2, 32'd5, 1'b0);
    pinIn[7] = 1'b1;
    issue(4'd2, 32'd7, 1'b0);
    check("R9", "read before sync", {63'd0, carryOut}, 64'd0);
    @(negedge clk);
    issue(4'd2, 32'd7, 1'b0);
    check("R9", "read after sync", {63'd0, carryOut}, 64'd1);

    // R7: unbuilt index
    saveOut = pinOut; saveDir = pinDir;
    issue(4'd0, 32'd100, 1'b0);
    issue(4'd5, 32'd100, 1'b0);
    check("R7", "out unchanged", pinOut, saveOut);
    check("R7", "dir unchanged", pinDir, saveDir);
    issue(4'd2, 32'd100, 1'b0);
    check("R7", "read gives 0", {63'd0, carryOut}, 64'd0);
    issue(4'd8, 32'd64, 1'b0);
    check("R7", "wait no busy", {63'd0, busy}, 64'd0);

    // R8 wait-for-1 on pin 20, R12 start ignored while busy
    issue(4'd8, 32'd20, 1'b0);
    check("R8", "busy rises", {63'd0, busy}, 64'd1);
    issue(4'd0, 32'd21, 1'b0);
    check("R12", "set ignored while busy", {63'd0, pinOut[21]}, 64'd0);
    pinIn[20] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", "busy held before match", {63'd0, busy}, 64'd1);
    @(negedge clk);
    check("R8", "busy falls", {63'd0, busy}, 64'd0);

    // R8 wait-for-0 on pin 5
    issue(4'd7, 32'd5, 1'b0);
    check("R8", "wait0 busy", {63'd0, busy}, 64'd1);
    pinIn[5] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "wait0 held", {63'd0, busy}, 64'd1);
    @(negedge clk);
    check("R8", "wait0 done", {63'd0, busy}, 64'd0);

    // R12 undefined opcode
    saveOut = pinOut; saveDir = pinDir;
    issue(4'd9, 32'd10, 1'b1);
    check("R12", "undefined op out", pinOut, saveOut);
    check("R12", "undefined op dir", pinDir, saveDir);

    // R10 / R11 group writes with collision
    saveOut = pinOut; saveDir = pinDir;
    grpOutWe = 1'b1; grpOutData = 32'hFFFF_FFFF;
    issue(4'd1, 32'd3, 1'b0);
    grpOutWe = 1'b0;
    check("R11", "single pin wins", {32'd0, pinOut[31:0]}, 64'h0000_0000_FFFF_FFF7);
    check("R10", "upper out untouched", {32'd0, pinOut[63:32]}, {32'd0, saveOut[63:32]});
    grpDirWe = 1'b1; grpDirData = 32'h0000_00F0;
    @(negedge clk);
    grpDirWe = 1'b0;
    check("R10", "group dir", {32'd0, pinDir[31:0]}, 64'h0000_0000_0000_00F0);
    check("R10", "upper dir untouched", {32'd0, pinDir[63:32]}, {32'd0, saveDir[63:32]});
    check("R10", "grpIn", {32'd0, grpIn}, {32'd0, pinIn[31:0]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule